// File: doc/BRIEF.md
# CAN FD Operating-Mode Request Controller

This block keeps the operating mode of a CAN protocol engine. The engine can run in three modes: classic ISO 11898-1, FD, or FD with bit rate switching. A host writes a two-bit mode request and a two-bit enable field through a single-cycle write port. The block does not act on the request when it is written. It waits for the protocol engine to signal that it is idle between two frames. Only then does it check the request against the enable field and switch modes.

A request that is accepted changes the mode and updates the FD and bit-rate-switch flags in the same cycle, and the request field clears itself. A request for a mode the enable field does not allow stays in the request field until the host writes over it. The transmit path uses the registered mode and flag outputs. The request and enable fields can be read back on their own ports.

Top module: `fdm_mode_ctrl`

## Requirements
- R1: After a synchronous reset the mode is classic (code 0), both flags are 0, and the request and enable fields read 00.
- R2: A host write loads the request and enable fields on the next clock edge. The mode and flags never change in a cycle without an idle pulse.
- R3: On an idle pulse with no host write, an allowed request is applied and the request field returns to 00. Request 01 selects FD (mode code 1), request 10 selects FD with bit rate switching (mode code 2), and request 11 selects classic (mode code 0).
- R4: The FD flag is 1 in mode codes 1 and 2. The bit-rate-switch flag is 1 only in mode code 2. Both flags are 0 in classic mode.
- R5: On an idle pulse, a request for a mode that is not allowed leaves the request field unchanged. It remains until a later write overwrites it.
- R6: Enable 00 allows classic only. Enable 01 also allows FD. Enable 10 and 11 allow FD and FD with bit rate switching.
- R7: A classic request (11) is accepted under every enable value.
- R8: If a host write and an idle pulse occur in the same cycle, the write wins. Mode and flags do not change, and the written request is evaluated at the next idle pulse.
- R9: At an idle pulse, if the enable field no longer allows the current mode and no allowed request is pending, the mode falls back to classic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the request and enable fields |
| wr_req | input | 2 | Mode request value to write |
| wr_ena | input | 2 | Enable field value to write |
| idle_pulse | input | 1 | One-cycle pulse from the engine at the inter-frame idle point |
| mode_o | output | 2 | Current mode: 0 classic, 1 FD, 2 FD with bit rate switching |
| fd_on_o | output | 1 | FD operation flag |
| brs_on_o | output | 1 | Bit-rate-switch flag |
| req_o | output | 2 | Request field read-back |
| ena_o | output | 2 | Enable field read-back |

## Verification
The assertions assume that `idle_pulse` lasts exactly one cycle per idle point. They also assume that the mode register only ever holds codes 0 to 2, which the reset value and the decode of request codes keep true. The bench issues every host write as a single-cycle strobe. It raises `idle_pulse` only in isolated cycles, and only together with a write when it is testing the collision case. It sweeps every enable value, every request code and every starting mode. This covers all accept, retain and fallback paths without driving any input outside these assumptions.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  parameter int FIELD_W = 2;
  parameter int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_CLASSIC = 2'd0,
    MODE_FD      = 2'd1,
    MODE_FDBRS   = 2'd2
  } mode_t;

  localparam logic [FIELD_W-1:0] REQ_NONE    = 2'b00;
  localparam logic [FIELD_W-1:0] REQ_FD      = 2'b01;
  localparam logic [FIELD_W-1:0] REQ_FDBRS   = 2'b10;
  localparam logic [FIELD_W-1:0] REQ_CLASSIC = 2'b11;

  function automatic logic mode_allowed(mode_t m, logic [FIELD_W-1:0] ena);
    case (m)
      MODE_FD:    mode_allowed = (ena != 2'b00);
      MODE_FDBRS: mode_allowed = ena[1];
      default:    mode_allowed = 1'b1;
    endcase
  endfunction

  function automatic mode_t req_target(logic [FIELD_W-1:0] req);
    case (req)
      REQ_FD:    req_target = MODE_FD;
      REQ_FDBRS: req_target = MODE_FDBRS;
      default:   req_target = MODE_CLASSIC;
    endcase
  endfunction
endpackage

// File: rtl/fdm_field_reg.sv
module fdm_field_reg
  import fdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_req,
  input  logic [FIELD_W-1:0] wr_ena,
  input  logic               idle_pulse,
  input  logic               apply,
  output logic [FIELD_W-1:0] req_q,
  output logic [FIELD_W-1:0] ena_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= REQ_NONE;
      ena_q <= '0;
    end else if (wr_en) begin
      req_q <= wr_req;
      ena_q <= wr_ena;
    end else if (apply) begin
      req_q <= REQ_NONE;
    end
  end

  assert_req_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (apply && !wr_en) |=> (req_q == REQ_NONE));

  assert_req_retained_R5: assert property (@(posedge clk) disable iff (rst)
    (idle_pulse && !wr_en && !apply) |=> $stable(req_q));
endmodule

// File: rtl/fdm_mode_eval.sv
module fdm_mode_eval
  import fdm_pkg::*;
(
  input  logic               idle_pulse,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] req_q,
  input  logic [FIELD_W-1:0] ena_q,
  input  mode_t              cur_mode,
  output logic               load,
  output logic               apply,
  output mode_t              next_mode
);
  logic  eval;
  logic  req_ok;
  logic  cur_ok;
  mode_t tgt;

  always_comb begin
    eval   = idle_pulse && !wr_en;
    tgt    = req_target(req_q);
    req_ok = (req_q != REQ_NONE) && mode_allowed(tgt, ena_q);
    cur_ok = mode_allowed(cur_mode, ena_q);
    apply  = eval && req_ok;
    load   = eval;
    if (apply)
      next_mode = tgt;
    else if (!cur_ok)
      next_mode = MODE_CLASSIC;
    else
      next_mode = cur_mode;
  end
endmodule

// File: rtl/fdm_mode_state.sv
module fdm_mode_state
  import fdm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  mode_t next_mode,
  input  logic  idle_pulse,
  input  logic  wr_en,
  output mode_t mode_q,
  output logic  fd_q,
  output logic  brs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CLASSIC;
      fd_q   <= 1'b0;
      brs_q  <= 1'b0;
    end else if (load) begin
      mode_q <= next_mode;
      fd_q   <= (next_mode != MODE_CLASSIC);
      brs_q  <= (next_mode == MODE_FDBRS);
    end
  end

  assert_flags_match_R4: assert property (@(posedge clk) disable iff (rst)
    (fd_q == (mode_q != MODE_CLASSIC)) && (brs_q == (mode_q == MODE_FDBRS)));

  assert_hold_no_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !idle_pulse |=> ($stable(mode_q) && $stable(fd_q) && $stable(brs_q)));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (idle_pulse && wr_en) |=> $stable(mode_q));

  assert_brs_needs_fd_R4: assert property (@(posedge clk) disable iff (rst)
    brs_q |-> fd_q);
endmodule

// File: rtl/fdm_mode_ctrl.sv
module fdm_mode_ctrl
  import fdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_req,
  input  logic [FIELD_W-1:0] wr_ena,
  input  logic               idle_pulse,
  output logic [MODE_W-1:0]  mode_o,
  output logic               fd_on_o,
  output logic               brs_on_o,
  output logic [FIELD_W-1:0] req_o,
  output logic [FIELD_W-1:0] ena_o
);
  logic [FIELD_W-1:0] req_q;
  logic [FIELD_W-1:0] ena_q;
  logic               load;
  logic               apply;
  mode_t              next_mode;
  mode_t              mode_q;
  logic               fd_q;
  logic               brs_q;

  fdm_field_reg u_fields (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_req(wr_req), .wr_ena(wr_ena),
    .idle_pulse(idle_pulse), .apply(apply), .req_q(req_q), .ena_q(ena_q)
  );

  fdm_mode_eval u_eval (
    .idle_pulse(idle_pulse), .wr_en(wr_en), .req_q(req_q), .ena_q(ena_q),
    .cur_mode(mode_q), .load(load), .apply(apply), .next_mode(next_mode)
  );

  fdm_mode_state u_state (
    .clk(clk), .rst(rst), .load(load), .next_mode(next_mode),
    .idle_pulse(idle_pulse), .wr_en(wr_en),
    .mode_q(mode_q), .fd_q(fd_q), .brs_q(brs_q)
  );

  assign mode_o   = mode_q;
  assign fd_on_o  = fd_q;
  assign brs_on_o = brs_q;
  assign req_o    = req_q;
  assign ena_o    = ena_q;

  assert_classic_always_R7: assert property (@(posedge clk) disable iff (rst)
    (idle_pulse && !wr_en && req_q == REQ_CLASSIC) |=> (mode_o == 2'd0 && req_o == REQ_NONE));
endmodule

// File: tb/fdm_mode_ctrl_tb.sv
module fdm_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_req = 2'b00;
  logic [1:0] wr_ena = 2'b00;
  logic       idle_pulse = 1'b0;
  logic [1:0] mode_o;
  logic       fd_on_o;
  logic       brs_on_o;
  logic [1:0] req_o;
  logic [1:0] ena_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fdm_mode_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_req(wr_req), .wr_ena(wr_ena),
    .idle_pulse(idle_pulse), .mode_o(mode_o), .fd_on_o(fd_on_o),
    .brs_on_o(brs_on_o), .req_o(req_o), .ena_o(ena_o)
  );

  task automatic chk(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic bit ok_mode(int m, int e);
    if (m == 1) return e != 0;
    if (m == 2) return e >= 2;
    return 1;
  endfunction

  function automatic int tgt_of(int r);
    if (r == 1) return 1;
    if (r == 2) return 2;
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic host_wr(int r, int e);
    @(negedge clk); wr_en = 1'b1; wr_req = r[1:0]; wr_ena = e[1:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_idle();
    @(negedge clk); idle_pulse = 1'b1;
    @(negedge clk); idle_pulse = 1'b0;
  endtask

  task automatic chk_mode(string tag, int m);
    chk(tag, mode_o, m);
    chk("R4 fd flag", fd_on_o, (m != 0) ? 1 : 0);
    chk("R4 brs flag", brs_on_o, (m == 2) ? 1 : 0);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk_mode("R1 reset mode", 0);
    chk("R1 reset req", req_o, 0);
    chk("R1 reset ena", ena_o, 0);

    for (int e = 0; e < 4; e++) begin
      for (int r = 0; r < 4; r++) begin
        for (int s = 0; s < 3; s++) begin
          int sreq;
          int exp_m;
          int exp_r;
          string tag;
          do_reset();
          sreq = (s == 0) ? 3 : s;
          host_wr(sreq, 2);
          pulse_idle();
          chk_mode("R3 start mode", s);
          host_wr(r, e);
          chk("R2 req loaded", req_o, r);
          chk("R2 ena loaded", ena_o, e);
          repeat (3) @(negedge clk);
          chk_mode("R2 no change before idle", s);
          pulse_idle();
          if (r != 0 && ok_mode(tgt_of(r), e)) begin
            exp_m = tgt_of(r); exp_r = 0;
            tag = (r == 3) ? "R7 classic accepted" : "R3/R6 request applied";
          end else begin
            exp_m = ok_mode(s, e) ? s : 0; exp_r = r;
            tag = (r == 0) ? "R9 fallback/hold" : "R5/R6 disallowed kept";
          end
          chk_mode(tag, exp_m);
          chk("R3/R5 req after idle", req_o, exp_r);
        end
      end
    end

    // R5: retained request, later overwritten
    do_reset();
    host_wr(1, 0);
    pulse_idle();
    pulse_idle();
    chk("R5 retained over two idles", req_o, 1);
    chk_mode("R5 mode stays classic", 0);
    host_wr(2, 2);
    chk("R5 overwrite", req_o, 2);
    pulse_idle();
    chk_mode("R5 overwritten request applied", 2);

    // R8: write and idle in same cycle
    do_reset();
    @(negedge clk);
    wr_en = 1'b1; wr_req = 2'd1; wr_ena = 2'd2; idle_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; idle_pulse = 1'b0;
    chk_mode("R8 collision no change", 0);
    chk("R8 collision req kept", req_o, 1);
    pulse_idle();
    chk_mode("R8 applied at next idle", 1);
    chk("R8 req cleared", req_o, 0);

    // R9: enable removed while in FD+BRS with no request
    host_wr(2, 2);
    pulse_idle();
    chk_mode("R9 in brs", 2);
    host_wr(0, 1);
    chk_mode("R9 no fallback before idle", 2);
    pulse_idle();
    chk_mode("R9 fallback classic", 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule